// File: doc/BRIEF.md
# Interrupt Priority Masking Unit

This unit decides on every instruction cycle (one clock) whether a CPU core may take a pending interrupt, and which one it takes. Each of up to eight request lines has its own 3-bit priority. A request competes only if its priority is above the CPU's current 3-bit priority level. It must also pass two further gates: a timed hold-off and a nesting lock.

The timed hold-off is started by a one-cycle command that carries a cycle count. Until that count has run down, it blocks priorities 1 to 6 and lets priority 7 through. A new command always reloads the count and restarts masking. This includes a command that lands in the cycle in which the count is already zero. The nesting lock, when enabled, blocks every request while the core reports that a handler is running.

The unit accepts a request with a one-cycle strobe, together with the source index and the winning priority. The core can use that priority to raise its own level.

Top module: `irq_admit`

## Requirements
- R1: A source competes only if its pending bit is set, its priority is non-zero, and its priority is strictly greater than `cpuLevel`. Source i's priority sits at `reqPrio[3*i+2:3*i]`, and priority 0 means the source is disabled.
- R2: A hold-off command with count N masks the command's own cycle and the N cycles after it, so N+1 cycles in all. With N=0, only the command cycle is masked.
- R3: While the hold-off is active, priorities 1 to 6 are refused and priority 7 can still be accepted.
- R4: A hold-off command issued while the count is still non-zero reloads the count with the new value. Masking continues with no unmasked cycle in between.
- R5: A hold-off command issued in a cycle where the count is already zero masks that cycle and loads the new count. Masking then continues for the new count.
- R6: Among eligible sources, the highest priority wins. On a tie, the lowest source index wins.
- R7: With `nestOff`=1 and `inHandler`=1, no request is accepted, including priority 7. With `nestOff`=0, a higher-priority request is accepted while `inHandler`=1.
- R8: `takeStb` is registered and rises one clock after the decision cycle. It is never high in two consecutive cycles. `takeIdx` and `takePrio` carry the winner while `takeStb` is high and read 0 otherwise.
- R9: After reset, the hold-off count is 0, no mask is active, and `takeStb`, `takeIdx` and `takePrio` are 0.
- R10: With `cpuLevel` = 3'b111, no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuLevel | input | 3 | Current CPU priority level |
| reqPend | input | NSRC | Pending flag per source |
| reqPrio | input | 3*NSRC | Priority per source, 3 bits each |
| holdCmd | input | 1 | Timed hold-off command strobe |
| holdCount | input | CNTW | Cycle count carried by the command |
| nestOff | input | 1 | 1 = no nesting while a handler runs |
| inHandler | input | 1 | Core is executing a handler |
| takeStb | output | 1 | One-cycle accept strobe |
| takeIdx | output | $clog2(NSRC) | Index of the accepted source |
| takePrio | output | 3 | Priority of the accepted source |

## Verification
The hardest situation to reach is a hold-off command that lands exactly in the first cycle in which the previous count has reached zero. The stimulus issues a short hold-off and keeps a priority-5 request pending throughout. It then counts clocks from the command so that the second command meets the zero-count cycle exactly, and it checks that the request stays refused until the second count has run out. The boundary where a reload arrives one cycle earlier, with the count still non-zero, is driven in the same way.

// File: rtl/irq_admit_pkg.sv
package irq_admit_pkg;
  localparam int PRIO_W = 3;
  localparam logic [PRIO_W-1:0] PRIO_TOP = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic holdMask;   // levels 1..6 refused this cycle
    logic nestBlock;  // every level refused this cycle
    logic coolDown;   // accept issued last cycle
  } ctl_t;
endpackage

// File: rtl/irq_admit_ctrl.sv
module irq_admit_ctrl
  import irq_admit_pkg::*;
#(
  parameter int CNTW = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            holdCmd,
  input  logic [CNTW-1:0] holdCount,
  input  logic            nestOff,
  input  logic            inHandler,
  input  logic            takeStb,
  output ctl_t            ctl
);
  logic [CNTW-1:0] holdCnt;
  logic            cntLive;

  // A command always wins over the decrement, whatever the count is.
  always_ff @(posedge clk) begin
    if (!rstN)              holdCnt <= '0;
    else if (holdCmd)       holdCnt <= holdCount;
    else if (cntLive)       holdCnt <= holdCnt - 1'b1;
  end

  assign cntLive = (holdCnt != '0);

  always_comb begin
    ctl.holdMask  = holdCmd | cntLive;
    ctl.nestBlock = nestOff & inHandler;
    ctl.coolDown  = takeStb;
  end

  // R2
  hold_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!holdCmd && holdCnt != '0) |=> holdCnt == $past(holdCnt) - 1'b1);
  // R4
  hold_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCmd |=> holdCnt == $past(holdCount));
  // R5
  hold_reengage_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCmd && holdCount != '0) |=> ctl.holdMask);
  // R9
  hold_idle_chk: assert property (@(posedge clk)
    $past(!rstN) |-> holdCnt == '0);
endmodule

// File: rtl/irq_admit_dp.sv
module irq_admit_dp
  import irq_admit_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRIO_W-1:0]    cpuLevel,
  input  logic [NSRC-1:0]      reqPend,
  input  logic [PRIO_W*NSRC-1:0] reqPrio,
  input  ctl_t                 ctl,
  output logic                 takeStb,
  output logic [IDXW-1:0]      takeIdx,
  output logic [PRIO_W-1:0]    takePrio
);
  logic [NSRC-1:0] srcOk;
  logic [PRIO_W-1:0] prioOf [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign prioOf[i] = reqPrio[PRIO_W*i +: PRIO_W];
    assign srcOk[i]  = reqPend[i]
                     && (prioOf[i] != '0)
                     && (prioOf[i] > cpuLevel)
                     && !(ctl.holdMask && prioOf[i] != PRIO_TOP);
  end

  logic              anyWin;
  logic [IDXW-1:0]   winIdx;
  logic [PRIO_W-1:0] winPrio;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    anyWin  = 1'b0;
    winIdx  = '0;
    winPrio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (srcOk[i] && (!anyWin || prioOf[i] > winPrio)) begin
        anyWin  = 1'b1;
        winIdx  = IDXW'(i);
        winPrio = prioOf[i];
      end
    end
  end

  logic grant;
  assign grant = anyWin && !ctl.nestBlock && !ctl.coolDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeStb  <= 1'b0;
      takeIdx  <= '0;
      takePrio <= '0;
    end else begin
      takeStb  <= grant;
      takeIdx  <= grant ? winIdx  : '0;
      takePrio <= grant ? winPrio : '0;
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |=> !takeStb);
  // R1
  above_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |-> takePrio > $past(cpuLevel));
  // R3
  hold_pass7_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdMask |=> (!takeStb || takePrio == PRIO_TOP));
  // R7
  nest_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nestBlock |=> !takeStb);
  // R10
  top_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuLevel == PRIO_TOP) |=> !takeStb);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeStb |-> (takeIdx == '0 && takePrio == '0));
endmodule

// File: rtl/irq_admit.sv
module irq_admit
  import irq_admit_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int CNTW = 14,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             cpuLevel,
  input  logic [NSRC-1:0]        reqPend,
  input  logic [3*NSRC-1:0]      reqPrio,
  input  logic                   holdCmd,
  input  logic [CNTW-1:0]        holdCount,
  input  logic                   nestOff,
  input  logic                   inHandler,
  output logic                   takeStb,
  output logic [IDXW-1:0]        takeIdx,
  output logic [2:0]             takePrio
);
  ctl_t ctl;

  irq_admit_ctrl #(.CNTW(CNTW)) u_ctrl (
    .clk(clk), .rstN(rstN), .holdCmd(holdCmd), .holdCount(holdCount),
    .nestOff(nestOff), .inHandler(inHandler), .takeStb(takeStb), .ctl(ctl)
  );

  irq_admit_dp #(.NSRC(NSRC)) u_dp (
    .clk(clk), .rstN(rstN), .cpuLevel(cpuLevel), .reqPend(reqPend),
    .reqPrio(reqPrio), .ctl(ctl), .takeStb(takeStb), .takeIdx(takeIdx),
    .takePrio(takePrio)
  );
endmodule

// File: tb/irq_admit_test.sv
module irq_admit_test;
  localparam int NSRC = 8;
  localparam int CNTW = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cpuLevel = '0;
  logic [NSRC-1:0] reqPend = '0;
  logic [3*NSRC-1:0] reqPrio = '0;
  logic holdCmd = 1'b0;
  logic [CNTW-1:0] holdCount = '0;
  logic nestOff = 1'b0;
  logic inHandler = 1'b0;
  logic takeStb;
  logic [2:0] takeIdx;
  logic [2:0] takePrio;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_admit #(.NSRC(NSRC), .CNTW(CNTW)) uut (
    .clk(clk), .rstN(rstN), .cpuLevel(cpuLevel), .reqPend(reqPend),
    .reqPrio(reqPrio), .holdCmd(holdCmd), .holdCount(holdCount),
    .nestOff(nestOff), .inHandler(inHandler), .takeStb(takeStb),
    .takeIdx(takeIdx), .takePrio(takePrio)
  );

  typedef struct packed {
    logic [2:0]  lvl;
    logic [7:0]  pend;
    logic [23:0] prio;   // octal digit i = source i
    logic        nest;
    logic        inh;
    logic        eStb;
    logic [2:0]  eIdx;
    logic [2:0]  ePrio;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'h01, 24'o00000003, 1'b0, 1'b0, 1'b1, 3'd0, 3'd3}, // R1 above level
    '{3'd3, 8'h01, 24'o00000003, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}, // R1 equal refused
    '{3'd0, 8'hFF, 24'o12345670, 1'b0, 1'b0, 1'b1, 3'd1, 3'd7}, // R6 highest
    '{3'd0, 8'h34, 24'o00550500, 1'b0, 1'b0, 1'b1, 3'd2, 3'd5}, // R6 tie low idx
    '{3'd0, 8'h01, 24'o00000000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}, // R1 prio 0
    '{3'd7, 8'hFF, 24'o77777777, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}, // R10
    '{3'd2, 8'h08, 24'o00006000, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0}, // R7 locked
    '{3'd2, 8'h08, 24'o00006000, 1'b0, 1'b1, 1'b1, 3'd3, 3'd6}, // R7 nesting
    '{3'd2, 8'h08, 24'o00006000, 1'b1, 1'b0, 1'b1, 3'd3, 3'd6}, // R7 no handler
    '{3'd2, 8'h08, 24'o00007000, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0}, // R7 level 7 too
    '{3'd0, 8'h00, 24'o77777777, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}  // R1 not pending
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [6:0] exp);
    logic [6:0] act;
    act = {takeStb, takeIdx, takePrio};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got stb/idx/prio=%b/%0d/%0d expected %b/%0d/%0d",
               tag, act[6], act[5:3], act[2:0], exp[6], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic idle();
    reqPend = '0; holdCmd = 1'b0; nestOff = 1'b0; inHandler = 1'b0;
    cpuLevel = '0;
    repeat (20) tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R9 reset outputs", 7'b0);
    rstN = 1'b1;
    tick();
    chk("R9 after reset idle", 7'b0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      cpuLevel = VECS[v].lvl; reqPend = VECS[v].pend; reqPrio = VECS[v].prio;
      nestOff = VECS[v].nest; inHandler = VECS[v].inh;
      tick();
      chk($sformatf("vector %0d", v), {VECS[v].eStb, VECS[v].eIdx, VECS[v].ePrio});
      reqPend = '0;
      tick();
    end
    idle();

    // R8 held request pulses every other cycle
    reqPend = 8'h01; reqPrio = 24'o00000004;
    tick(); chk("R8 first pulse", {1'b1, 3'd0, 3'd4});
    tick(); chk("R8 gap after pulse", 7'b0);
    tick(); chk("R8 next pulse", {1'b1, 3'd0, 3'd4});
    idle();

    // R2 N=3 masks 4 cycles
    reqPrio = 24'o00000005;
    reqPend = 8'h01; holdCmd = 1'b1; holdCount = 14'd3;
    tick(); holdCmd = 1'b0;
    chk("R2 command cycle masked", 7'b0);
    for (int k = 0; k < 3; k++) begin
      tick(); chk($sformatf("R2 count cycle %0d masked", k), 7'b0);
    end
    tick(); chk("R2 accept after expiry", {1'b1, 3'd0, 3'd5});
    idle();

    // R2 N=0 masks command cycle only
    reqPrio = 24'o00000005;
    reqPend = 8'h01; holdCmd = 1'b1; holdCount = 14'd0;
    tick(); holdCmd = 1'b0;
    chk("R2 N=0 command cycle", 7'b0);
    tick(); chk("R2 N=0 accept next", {1'b1, 3'd0, 3'd5});
    idle();

    // R3 level 7 passes, level 6 blocked during hold-off
    reqPend = 8'h03; reqPrio = 24'o00000076; holdCmd = 1'b1; holdCount = 14'd5;
    tick(); holdCmd = 1'b0;
    chk("R3 level 7 passes hold-off", {1'b1, 3'd1, 3'd7});
    reqPend = 8'h01;
    tick(); tick();
    chk("R3 level 6 blocked", 7'b0);
    idle();

    // R4 reload while count non-zero
    reqPrio = 24'o00000005;
    reqPend = 8'h01; holdCmd = 1'b1; holdCount = 14'd3;
    tick(); holdCmd = 1'b0; chk("R4 c0", 7'b0);          // count now 3
    tick(); chk("R4 c1", 7'b0);                           // count now 2
    holdCmd = 1'b1; holdCount = 14'd2;
    tick(); holdCmd = 1'b0; chk("R4 reload cycle", 7'b0); // count now 2
    tick(); chk("R4 c3", 7'b0);
    tick(); chk("R4 c4", 7'b0);
    tick(); chk("R4 accept after reload", {1'b1, 3'd0, 3'd5});
    idle();

    // R5 command in the cycle the count is zero
    reqPrio = 24'o00000005;
    reqPend = 8'h01; holdCmd = 1'b1; holdCount = 14'd2;
    tick(); holdCmd = 1'b0; chk("R5 c0", 7'b0);  // count 2
    tick(); chk("R5 c1", 7'b0);                  // count 1
    tick(); chk("R5 c2", 7'b0);                  // count 0
    holdCmd = 1'b1; holdCount = 14'd2;
    tick(); holdCmd = 1'b0; chk("R5 zero-count command", 7'b0);
    tick(); chk("R5 re-engaged 1", 7'b0);
    tick(); chk("R5 re-engaged 2", 7'b0);
    tick(); chk("R5 accept after new count", {1'b1, 3'd0, 3'd5});
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule